// File: doc/BRIEF.md
# Error Logging and Steering Unit

This unit gathers one-cycle error pulses from nine internal detectors, such as address parity, several data parity checks, a discard-timer expiry and observed system-error or parity-error assertions. It holds them in two capture registers. The first error seen after a clear lands in the primary capture register, which then holds it until software clears it. Errors that arrive while the primary register is occupied go to a secondary capture register, so a second fault is not lost while the first is being handled. A two-bit summary register shows which capture register holds anything.

Each source has a mask bit and three routing bits, and the routing bits pick a fatal-reset output, a system-error output and an interrupt request. A mask bit only silences signaling. Recording always happens, so software can poll for errors it does not treat as fatal. All three outputs are driven from the OR of both capture registers, which lets an interrupt for one fault and a fatal reset for another appear close together. A single command bit turns fatal escalation off for every source. Software reaches all registers through a small address, write-enable and data port, and clears the capture registers by writing ones.

Top module: `errlog_steer`

## Requirements
- R1: When the primary capture register (address 5) is empty, every source pulsing at the same clock edge is recorded there together, and the secondary register is not changed.
- R2: While the primary register holds any bit, new error pulses are ORed into the secondary register (address 6) and the primary register keeps its value.
- R3: An error is recorded in a capture register whether or not its mask bit (address 1, bit i for source i) is set.
- R4: A source whose mask bit is 1 does not contribute to any of the three outputs.
- R5: The summary register (address 7) reads bit 0 = primary register nonzero and bit 1 = secondary register nonzero. All other bits read 0.
- R6: fatal_n goes low when an unmasked source that is set in either capture register has its bit set in the fatal route register (address 2) and command bit 0 (address 0) is 0. When command bit 0 is 1, fatal_n stays high for every source.
- R7: serr_n (active low) follows the system-error route register (address 3) and irq (active high) follows the interrupt route register (address 4). Each output is decided independently of the other two routes.
- R8: The outputs are registered. They reflect the OR of both capture registers one clock after that content changes, so a bit held only in the secondary register still signals.
- R9: Writing to address 5 or 6 clears each bit written as 1 and leaves each bit written as 0. An output released by a clear deasserts one clock after the clearing write.
- R10: If a write to address 5 and an error pulse share an edge, the primary register is first reduced by the clear. If it is then empty, the new errors go into it; otherwise they go to the secondary register.
- R11: After reset all registers read 0, fatal_n and serr_n are 1 and irq is 0.
- R12: Reads are combinational from reg_addr. Addresses 0 to 4 are read-write configuration, with source i at bit i of addresses 1 to 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_pulse | input | NSRC | One-cycle error pulses, one bit per source |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr |
| fatal_n | output | 1 | Fatal-reset request, active low |
| serr_n | output | 1 | System-error signal, active low |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench drives pulses that share an edge, and expects them all in the primary register; a design that spilled part of them into the secondary register would fail. It sends a second pulse of the same source and a pulse that arrives only after the primary register is empty, catching designs that choose the register by source instead of by occupancy. It writes a clear on the same edge as a new error, both a full and a partial clear, so a design that tested occupancy before applying the clear would lose the new error or misfile it. It also checks that masked errors are still recorded while staying silent, that the command bit blocks only the fatal output, and that writing zero leaves a capture bit standing.

// File: rtl/errlog_pkg.sv
package errlog_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CMD      = 3'd0,
        REG_MASK     = 3'd1,
        REG_RT_FATAL = 3'd2,
        REG_RT_SERR  = 3'd3,
        REG_RT_IRQ   = 3'd4,
        REG_FIRST    = 3'd5,
        REG_NEXT     = 3'd6,
        REG_SUMM     = 3'd7
    } reg_addr_e;

    localparam int CMD_FATAL_OFF_BIT = 0;
    localparam int SUMM_FIRST_BIT    = 0;
    localparam int SUMM_NEXT_BIT     = 1;
endpackage

// File: rtl/errlog_cfg.sv
module errlog_cfg
    import errlog_pkg::*;
#(
    parameter int NSRC = 9,
    parameter int DW   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic              fatal_off,
    output logic [NSRC-1:0]   mask,
    output logic [NSRC-1:0]   rt_fatal,
    output logic [NSRC-1:0]   rt_serr,
    output logic [NSRC-1:0]   rt_irq
);
    typedef struct packed {
        logic            off;
        logic [NSRC-1:0] mask;
        logic [NSRC-1:0] rf;
        logic [NSRC-1:0] rs;
        logic [NSRC-1:0] ri;
    } cfg_t;

    cfg_t      cfg_d, cfg_q;
    reg_addr_e sel;

    assign sel = reg_addr_e'(addr);

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (sel)
                REG_CMD:      cfg_d.off  = wdata[CMD_FATAL_OFF_BIT];
                REG_MASK:     cfg_d.mask = wdata[NSRC-1:0];
                REG_RT_FATAL: cfg_d.rf   = wdata[NSRC-1:0];
                REG_RT_SERR:  cfg_d.rs   = wdata[NSRC-1:0];
                REG_RT_IRQ:   cfg_d.ri   = wdata[NSRC-1:0];
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign fatal_off = cfg_q.off;
    assign mask      = cfg_q.mask;
    assign rt_fatal  = cfg_q.rf;
    assign rt_serr   = cfg_q.rs;
    assign rt_irq    = cfg_q.ri;
endmodule

// File: rtl/errlog_capture.sv
module errlog_capture #(
    parameter int NSRC = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] err,
    input  logic [NSRC-1:0] clr_first,
    input  logic [NSRC-1:0] clr_next,
    output logic [NSRC-1:0] first_q,
    output logic [NSRC-1:0] next_q
);
    typedef struct packed {
        logic [NSRC-1:0] first;
        logic [NSRC-1:0] next;
    } cap_t;

    cap_t            cap_d, cap_q;
    logic [NSRC-1:0] first_kept;
    logic [NSRC-1:0] next_kept;
    logic            occupied;

    always_comb begin
        first_kept = cap_q.first & ~clr_first;
        next_kept  = cap_q.next  & ~clr_next;
        occupied   = |first_kept;
        cap_d.first = first_kept;
        cap_d.next  = next_kept;
        if (occupied) cap_d.next  = next_kept | err;
        else          cap_d.first = err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign first_q = cap_q.first;
    assign next_q  = cap_q.next;
endmodule

// File: rtl/errlog_out.sv
module errlog_out #(
    parameter int NSRC = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] first_q,
    input  logic [NSRC-1:0] next_q,
    input  logic [NSRC-1:0] mask,
    input  logic [NSRC-1:0] rt_fatal,
    input  logic [NSRC-1:0] rt_serr,
    input  logic [NSRC-1:0] rt_irq,
    input  logic            fatal_off,
    output logic            fatal_n,
    output logic            serr_n,
    output logic            irq
);
    typedef struct packed {
        logic fatal_n;
        logic serr_n;
        logic irq;
    } sig_t;

    localparam sig_t SIG_IDLE = '{fatal_n: 1'b1, serr_n: 1'b1, irq: 1'b0};

    sig_t            sig_d, sig_q;
    logic [NSRC-1:0] live;

    always_comb begin
        live          = (first_q | next_q) & ~mask;
        sig_d.fatal_n = !(!fatal_off && |(live & rt_fatal));
        sig_d.serr_n  = !(|(live & rt_serr));
        sig_d.irq     = |(live & rt_irq);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= SIG_IDLE;
        else        sig_q <= sig_d;
    end

    assign fatal_n = sig_q.fatal_n;
    assign serr_n  = sig_q.serr_n;
    assign irq     = sig_q.irq;
endmodule

// File: rtl/errlog_steer.sv
module errlog_steer
    import errlog_pkg::*;
#(
    parameter int NSRC = 9,
    parameter int DW   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   err_pulse,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              fatal_n,
    output logic              serr_n,
    output logic              irq
);
    localparam int PAD = DW - NSRC;

    logic            fatal_off;
    logic [NSRC-1:0] mask, rt_fatal, rt_serr, rt_irq;
    logic [NSRC-1:0] first_q, next_q;
    logic [NSRC-1:0] clr_first, clr_next;
    reg_addr_e       sel;

    assign sel       = reg_addr_e'(reg_addr);
    assign clr_first = (reg_we && sel == REG_FIRST) ? reg_wdata[NSRC-1:0] : '0;
    assign clr_next  = (reg_we && sel == REG_NEXT)  ? reg_wdata[NSRC-1:0] : '0;

    errlog_cfg #(.NSRC(NSRC), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .fatal_off(fatal_off), .mask(mask),
        .rt_fatal(rt_fatal), .rt_serr(rt_serr), .rt_irq(rt_irq)
    );

    errlog_capture #(.NSRC(NSRC)) u_cap (
        .clk(clk), .rst_n(rst_n), .err(err_pulse),
        .clr_first(clr_first), .clr_next(clr_next),
        .first_q(first_q), .next_q(next_q)
    );

    errlog_out #(.NSRC(NSRC)) u_out (
        .clk(clk), .rst_n(rst_n), .first_q(first_q), .next_q(next_q),
        .mask(mask), .rt_fatal(rt_fatal), .rt_serr(rt_serr),
        .rt_irq(rt_irq), .fatal_off(fatal_off),
        .fatal_n(fatal_n), .serr_n(serr_n), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (sel)
            REG_CMD:      reg_rdata[CMD_FATAL_OFF_BIT] = fatal_off;
            REG_MASK:     reg_rdata = {{PAD{1'b0}}, mask};
            REG_RT_FATAL: reg_rdata = {{PAD{1'b0}}, rt_fatal};
            REG_RT_SERR:  reg_rdata = {{PAD{1'b0}}, rt_serr};
            REG_RT_IRQ:   reg_rdata = {{PAD{1'b0}}, rt_irq};
            REG_FIRST:    reg_rdata = {{PAD{1'b0}}, first_q};
            REG_NEXT:     reg_rdata = {{PAD{1'b0}}, next_q};
            REG_SUMM: begin
                reg_rdata[SUMM_FIRST_BIT] = |first_q;
                reg_rdata[SUMM_NEXT_BIT]  = |next_q;
            end
            default:      reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/errlog_steer_chk.sv
module errlog_steer_chk #(
    parameter int NSRC = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] err_pulse,
    input logic [2:0]      reg_addr,
    input logic            reg_we,
    input logic [NSRC-1:0] first_q,
    input logic [NSRC-1:0] next_q,
    input logic [NSRC-1:0] mask,
    input logic [NSRC-1:0] rt_serr,
    input logic            fatal_off,
    input logic            fatal_n,
    input logic            serr_n,
    input logic            irq
);
    p_first_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((|first_q) && !(reg_we && reg_addr == 3'd5)) |=> $stable(first_q));

    p_next_after_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|next_q) |-> $past(|first_q));

    p_err_recorded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_pulse) |=> (|first_q));

    p_serr_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (((first_q | next_q) & ~mask & rt_serr) == '0) |=> serr_n);

    p_fatal_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_off |=> fatal_n);

    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (first_q == '0 && next_q == '0) |=> (fatal_n && serr_n && !irq));
endmodule

bind errlog_steer errlog_steer_chk #(.NSRC(NSRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .reg_addr(reg_addr),
    .reg_we(reg_we), .first_q(first_q), .next_q(next_q), .mask(mask),
    .rt_serr(rt_serr), .fatal_off(fatal_off), .fatal_n(fatal_n),
    .serr_n(serr_n), .irq(irq)
);

// File: tb/errlog_steer_test.sv
module errlog_steer_test;
    localparam int NSRC = 9;
    localparam int DW   = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] err_pulse = '0;
    logic [2:0]      reg_addr = '0;
    logic            reg_we = 1'b0;
    logic [DW-1:0]   reg_wdata = '0;
    logic [DW-1:0]   reg_rdata;
    logic            fatal_n, serr_n, irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    errlog_steer #(.NSRC(NSRC), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .err_pulse(err_pulse), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fatal_n(fatal_n), .serr_n(serr_n), .irq(irq)
    );

    typedef struct packed {
        logic [8:0] mask, rf, rs, ri;
        logic       off;
        logic [8:0] ea, eb, xf, xn;
        logic       xfat_n, xserr_n, xirq;
    } vec_t;

    localparam vec_t TBL [0:5] = '{
        '{9'h000, 9'h001, 9'h000, 9'h000, 1'b0, 9'h001, 9'h000, 9'h001, 9'h000, 1'b0, 1'b1, 1'b0},
        '{9'h000, 9'h000, 9'h100, 9'h000, 1'b0, 9'h005, 9'h100, 9'h005, 9'h100, 1'b1, 1'b0, 1'b0},
        '{9'h002, 9'h1FF, 9'h1FF, 9'h1FF, 1'b0, 9'h002, 9'h000, 9'h002, 9'h000, 1'b1, 1'b1, 1'b0},
        '{9'h000, 9'h1FF, 9'h000, 9'h010, 1'b1, 9'h010, 9'h000, 9'h010, 9'h000, 1'b1, 1'b1, 1'b1},
        '{9'h000, 9'h000, 9'h020, 9'h040, 1'b0, 9'h020, 9'h020, 9'h020, 9'h020, 1'b1, 1'b0, 1'b0},
        '{9'h000, 9'h080, 9'h080, 9'h080, 1'b0, 9'h000, 9'h080, 9'h080, 9'h000, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #2;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [NSRC-1:0] e);
        @(negedge clk);
        err_pulse = e;
        @(negedge clk);
        err_pulse = '0;
    endtask

    task automatic clear_all();
        wr(3'd5, 16'h01FF);
        wr(3'd6, 16'h01FF);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            check("R11", "reset register", v, 0);
        end
        check("R11", "reset fatal_n", fatal_n, 1);
        check("R11", "reset serr_n", serr_n, 1);
        check("R11", "reset irq", irq, 0);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R12
        for (int i = 0; i < 6; i++) begin
            clear_all();
            wr(3'd1, {7'd0, TBL[i].mask});
            wr(3'd2, {7'd0, TBL[i].rf});
            wr(3'd3, {7'd0, TBL[i].rs});
            wr(3'd4, {7'd0, TBL[i].ri});
            wr(3'd0, {15'd0, TBL[i].off});
            pulse(TBL[i].ea);
            pulse(TBL[i].eb);
            rd(3'd5, v);
            check("R1/R2/R3", "primary capture", v, TBL[i].xf);
            check("R8", "fatal_n", fatal_n, TBL[i].xfat_n);
            check("R7", "serr_n", serr_n, TBL[i].xserr_n);
            check("R4/R7", "irq", irq, TBL[i].xirq);
            rd(3'd6, v);
            check("R2", "secondary capture", v, TBL[i].xn);
            rd(3'd7, v);
            check("R5", "summary", v, {TBL[i].xn != 0, TBL[i].xf != 0});
            rd(3'd2, v);
            check("R12", "fatal route readback", v, TBL[i].rf);
        end

        // R9: write-one-to-clear
        clear_all();
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0000);
        wr(3'd2, 16'h0000);
        wr(3'd3, 16'h0000);
        wr(3'd4, 16'h0003);
        pulse(9'h003);
        rd(3'd5, v);
        check("R9", "setup primary", v, 16'h0003);
        check("R9", "irq before clear", irq, 1);
        wr(3'd5, 16'h0001);
        rd(3'd5, v);
        check("R9", "partial clear", v, 16'h0002);
        wr(3'd5, 16'h0000);
        rd(3'd5, v);
        check("R9", "zero write keeps bits", v, 16'h0002);
        pulse(9'h004);
        rd(3'd6, v);
        check("R9", "secondary set", v, 16'h0004);
        wr(3'd6, 16'h0004);
        wr(3'd5, 16'h0002);
        rd(3'd7, v);
        check("R9", "summary after clear", v, 16'h0000);
        check("R9", "irq released", irq, 0);

        // R10: full clear coinciding with a new error
        pulse(9'h004);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 16'h01FF; err_pulse = 9'h008;
        @(negedge clk);
        reg_we = 1'b0; err_pulse = '0;
        rd(3'd5, v);
        check("R10", "full clear + error primary", v, 16'h0008);
        rd(3'd6, v);
        check("R10", "full clear + error secondary", v, 16'h0000);

        // R10: partial clear coinciding with a new error
        pulse(9'h004);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 16'h0004; err_pulse = 9'h001;
        @(negedge clk);
        reg_we = 1'b0; err_pulse = '0;
        rd(3'd5, v);
        check("R10", "partial clear + error primary", v, 16'h0008);
        rd(3'd6, v);
        check("R10", "partial clear + error secondary", v, 16'h0005);

        done = 1'b1;
        finish_run();
    end
endmodule